// File: doc/BRIEF.md
# Programmable 3x3 Color Space Converter

This block converts a stream of 8-bit, three-channel pixels from one color space to another. Each output channel is a weighted sum of the three input channels. The weights form a signed 3x3 matrix. A signed per-channel offset is then added, and the result is multiplied by a power-of-two gain. The value is rounded to the nearest integer and clamped, either to the full 8-bit range or to the video-legal range.

With suitable parameter sets it performs YCbCr-to-RGB, RGB-to-YCbCr, or a transparent RGB-to-RGB pass-through. The pass-through is used to feed graphics unchanged into a later combining stage.

Software writes six 32-bit parameter words into a staging bank. The staged set becomes active only with the first pixel of a frame, which is marked by a start-of-frame flag on the input stream. As a result, a frame is never converted with a mix of old and new parameters.

Pixels enter and leave on valid/ready streams. The datapath is three register stages deep, and all stages stall together under backpressure.

Top module: `csc_matrix_top`

## Requirements
- R1: After reset, `m_valid` is low, and the active and staged parameters hold the pass-through set: diagonal coefficients 128, all other coefficients 0, offsets 0, gain code 2, saturation off. With this set every pixel leaves unchanged.
- R2: Pixel packing and arithmetic.
  - Channel j of a pixel sits in bits [8j+7:8j] of `s_data` and `m_data`.
  - Output channel i is computed from the sum over j of c_ij times input channel j.
  - Each coefficient is a 9-bit two's-complement integer, so a raw 469 means -43.
- R3: Each channel offset k is a 13-bit two's-complement value with two fraction bits. It is added as offset/4 to (sum of c_ij * x_j)/256.
- R4: Gain and rounding.
  - The 2-bit gain code g multiplies the offset-adjusted sum by 2^(g-1). Codes 0, 1, 2 and 3 give gains of one half, 1, 2 and 4.
  - The result is rounded to nearest, with exact halves rounded up.
- R5: With saturation off, each output channel is clamped to 0..255.
- R6: With saturation on, output channel 0 (luma) is clamped to 16..235 and channels 1 and 2 are clamped to 16..240.
- R7: Parameter word layout.
  - Word 0 holds c00 in [26:18], c11 in [17:9] and c22 in [8:0].
  - Word 2 holds c01, c10 and c20 at the same positions. Word 4 holds c02, c12 and c21 at the same positions.
  - Offset k is split across two words: its bits [4:0] sit in bits [31:27] of word 2k, and its bits [12:5] sit in bits [7:0] of word 2k+1.
  - Word 1 also holds the gain code in [9:8] and the saturation flag in bit 10.
  - A write to an index above 5 is ignored.
- R8: Staging and activation.
  - A parameter write changes only the staging bank.
  - The staged set becomes active on the clock edge that accepts a pixel whose `s_sof` is high, and that pixel is already converted with the new set.
  - Pixels accepted without `s_sof` use the previously active set.
- R9: A pixel accepted on clock edge e is presented on `m_data`, with `m_valid` high, after edge e+2. This holds when the output side does not stall.
- R10: While `m_valid` is high and `m_ready` is low:
  - `m_data` holds its value;
  - `s_ready` is low;
  - no pixel is lost, duplicated or reordered.
- R11: `s_ready` is high whenever `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_idx | input | 3 | Parameter word index, 0..5 |
| cfg_data | input | 32 | Parameter word value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high together with s_valid |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_data | input | 24 | Input pixel, channel j in bits [8j+7:8j] |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream can take the output pixel |
| m_data | output | 24 | Converted pixel, channel i in bits [8i+7:8i] |

## Verification
The bench targets the points where the arithmetic is easy to get wrong:
- A raw coefficient of 469 must act as -43. A design that treats it as unsigned pushes that luma result to 255 instead of 16.
- Exact-half results at gains of one half and 1 must round up. A truncating design is off by one.
- Offsets of ±100.0 must push a channel past both ends of the range. A design with a missing or wrapped clamp returns wrapped values.
- In saturating mode, luma must clamp at 235 and chroma at 240. Swapping the two limits moves an output by 5.

Further directed cases cover the following:
- A parameter write without a frame start must not alter the output; a design that applies it early would.
- The off-diagonal word layout is checked, so swapped coefficient fields route the wrong input channel.
- The pipeline is held full under backpressure; a slip there drops or repeats a pixel.

Random traffic with random stalls and mid-stream parameter changes is compared against a reference model in the bench.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCH      = 3;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 9;
  localparam int OFS_W    = 13;
  localparam int OFS_LO_W = 5;
  localparam int OFS_HI_W = OFS_W - OFS_LO_W;
  localparam int SCL_W    = 2;
  localparam int NWORD    = 6;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = $clog2(NWORD);
  localparam int PROD_W   = COEF_W + PIX_W + 1;
  localparam int ACC_W    = PROD_W + $clog2(NCH) + 2;
  localparam int T_W      = ACC_W + (1 << SCL_W);
  localparam int FRAC_SH  = PIX_W + 1;
  localparam int OFS_SH   = PIX_W - 2;
  localparam int LUMA_MIN = 16;
  localparam int LUMA_MAX = 235;
  localparam int CHR_MAX  = 240;
  localparam int PIX_MAX  = (1 << PIX_W) - 1;

  typedef logic [NWORD-1:0][WORD_W-1:0] csc_words_t;

  typedef struct packed {
    logic [NCH-1:0][NCH-1:0][COEF_W-1:0] coef;
    logic [NCH-1:0][OFS_W-1:0]           ofs;
    logic [SCL_W-1:0]                    scale;
    logic                                sat;
  } csc_set_t;

  // Field positions are fixed by the parameter word layout (R7).
  function automatic csc_set_t csc_unpack(csc_words_t w);
    csc_set_t s;
    s.coef[0][0] = w[0][26:18];
    s.coef[1][1] = w[0][17:9];
    s.coef[2][2] = w[0][8:0];
    s.coef[0][1] = w[2][26:18];
    s.coef[1][0] = w[2][17:9];
    s.coef[2][0] = w[2][8:0];
    s.coef[0][2] = w[4][26:18];
    s.coef[1][2] = w[4][17:9];
    s.coef[2][1] = w[4][8:0];
    for (int k = 0; k < NCH; k++)
      s.ofs[k] = {w[2*k+1][OFS_HI_W-1:0], w[2*k][WORD_W-1 -: OFS_LO_W]};
    s.scale = w[1][9:8];
    s.sat   = w[1][10];
    return s;
  endfunction

  function automatic csc_words_t csc_identity();
    csc_words_t w;
    w    = '0;
    w[0] = (32'd128 << 18) | (32'd128 << 9) | 32'd128;
    w[1] = 32'd2 << 8;
    return w;
  endfunction
endpackage

// File: rtl/csc_param_bank.sv
module csc_param_bank
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output csc_set_t          eff
);
  csc_words_t words_q;
  csc_set_t   act_q;
  csc_set_t   staged;

  assign staged = csc_unpack(words_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= csc_identity();
      act_q   <= csc_unpack(csc_identity());
    end else begin
      if (wr_en && (int'(wr_idx) < NWORD))
        words_q[wr_idx] <= wr_data;
      if (take)
        act_q <= staged;
    end
  end

  // The frame's first pixel already uses the staged set.
  assign eff = take ? staged : act_q;

  assert_act_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(act_q))
    else $error("active set changed without frame start");
endmodule

// File: rtl/csc_mult_stage.sv
module csc_mult_stage
  import csc_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                en,
  input  logic                                v_in,
  input  logic [NCH-1:0][PIX_W-1:0]           pix,
  input  csc_set_t                            set,
  output logic                                v_o,
  output logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod_o,
  output logic [NCH-1:0][OFS_W-1:0]           ofs_o,
  output logic [SCL_W-1:0]                    scale_o,
  output logic                                sat_o
);
  logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod_c;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      for (int j = 0; j < NCH; j++) begin
        logic signed [PROD_W-1:0] a;
        logic signed [PROD_W-1:0] b;
        a = PROD_W'($signed(set.coef[i][j]));
        b = PROD_W'({1'b0, pix[j]});
        prod_c[i][j] = a * b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o     <= 1'b0;
      prod_o  <= '0;
      ofs_o   <= '0;
      scale_o <= '0;
      sat_o   <= 1'b0;
    end else if (en) begin
      v_o     <= v_in;
      prod_o  <= prod_c;
      ofs_o   <= set.ofs;
      scale_o <= set.scale;
      sat_o   <= set.sat;
    end
  end
endmodule

// File: rtl/csc_sum_stage.sv
module csc_sum_stage
  import csc_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                en,
  input  logic                                v_in,
  input  logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod,
  input  logic [NCH-1:0][OFS_W-1:0]           ofs,
  input  logic [SCL_W-1:0]                    scale,
  input  logic                                sat_in,
  output logic                                v_o,
  output logic [NCH-1:0][T_W-1:0]             t_o,
  output logic                                sat_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [T_W-1:0] acc;
    logic signed [T_W-1:0] t_c;
    logic        [T_W-1:0] t_q;

    always_comb begin
      acc = T_W'($signed(ofs[i])) <<< OFS_SH;
      for (int j = 0; j < NCH; j++)
        acc = acc + T_W'($signed(prod[i][j]));
      t_c = acc <<< scale;
    end

    always_ff @(posedge clk) begin
      if (rst)     t_q <= '0;
      else if (en) t_q <= t_c;
    end

    assign t_o[i] = t_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      sat_o <= 1'b0;
    end else if (en) begin
      v_o   <= v_in;
      sat_o <= sat_in;
    end
  end
endmodule

// File: rtl/csc_round_stage.sv
module csc_round_stage
  import csc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       v_in,
  input  logic [NCH-1:0][T_W-1:0]    t_in,
  input  logic                       sat_in,
  output logic                       v_o,
  output logic [NCH-1:0][PIX_W-1:0]  px_o
);
  localparam logic signed [T_W-1:0] HALF = T_W'(1) <<< (FRAC_SH - 1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int HI_SAT = (i == 0) ? LUMA_MAX : CHR_MAX;
    logic signed [T_W-1:0] r;
    logic signed [T_W-1:0] lo;
    logic signed [T_W-1:0] hi;
    logic [PIX_W-1:0]      y_c;
    logic [PIX_W-1:0]      y_q;

    always_comb begin
      r  = ($signed(t_in[i]) + HALF) >>> FRAC_SH;
      lo = sat_in ? T_W'(LUMA_MIN) : '0;
      hi = sat_in ? T_W'(HI_SAT) : T_W'(PIX_MAX);
      if (r < lo)      y_c = lo[PIX_W-1:0];
      else if (r > hi) y_c = hi[PIX_W-1:0];
      else             y_c = r[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)     y_q <= '0;
      else if (en) y_q <= y_c;
    end

    assign px_o[i] = y_q;

    assert_sat_range_R6: assert property (@(posedge clk) disable iff (rst)
      (en && v_in && sat_in) |=>
        (y_q >= PIX_W'(LUMA_MIN) && y_q <= PIX_W'(HI_SAT)))
      else $error("saturated output outside video range");
  end

  always_ff @(posedge clk) begin
    if (rst)     v_o <= 1'b0;
    else if (en) v_o <= v_in;
  end
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
  import csc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [WORD_W-1:0]     cfg_data,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic                  s_sof,
  input  logic [NCH*PIX_W-1:0]  s_data,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [NCH*PIX_W-1:0]  m_data
);
  logic                                en;
  logic                                take;
  csc_set_t                            eff;
  logic                                v1, v2, v3;
  logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod;
  logic [NCH-1:0][OFS_W-1:0]           ofs1;
  logic [SCL_W-1:0]                    scl1;
  logic                                sat1, sat2;
  logic [NCH-1:0][T_W-1:0]             t2;
  logic [NCH-1:0][PIX_W-1:0]           px3;

  // One enable for every stage: advance unless the output is held.
  assign en      = m_ready || !m_valid;
  assign s_ready = en;
  assign take    = s_valid && en && s_sof;

  csc_param_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(cfg_data), .take(take), .eff(eff)
  );

  csc_mult_stage u_mult (
    .clk(clk), .rst(rst), .en(en), .v_in(s_valid), .pix(s_data), .set(eff),
    .v_o(v1), .prod_o(prod), .ofs_o(ofs1), .scale_o(scl1), .sat_o(sat1)
  );

  csc_sum_stage u_sum (
    .clk(clk), .rst(rst), .en(en), .v_in(v1), .prod(prod), .ofs(ofs1),
    .scale(scl1), .sat_in(sat1), .v_o(v2), .t_o(t2), .sat_o(sat2)
  );

  csc_round_stage u_round (
    .clk(clk), .rst(rst), .en(en), .v_in(v2), .t_in(t2), .sat_in(sat2),
    .v_o(v3), .px_o(px3)
  );

  assign m_valid = v3;
  assign m_data  = px3;

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
    else $error("output changed while stalled");

  assert_ready_empty_R11: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> s_ready)
    else $error("input blocked with empty output");

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready)
    else $error("input accepted while output stalled");
endmodule

// File: tb/csc_matrix_top_test.sv
module csc_matrix_top_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_sof = 1'b0;
  logic [23:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [23:0] m_data;

  csc_matrix_top uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_sof(s_sof), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int ready_pct = 100;
  bit done = 1'b0;
  logic [31:0] bw_stage [6];
  logic [31:0] bw_act [6];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic logic [23:0] model(logic [31:0] w [6], logic [23:0] px);
    int c [3][3];
    int o [3];
    int sc;
    logic sat;
    logic [23:0] res;
    c[0][0] = sx(int'(w[0][26:18]), 9); c[1][1] = sx(int'(w[0][17:9]), 9);
    c[2][2] = sx(int'(w[0][8:0]), 9);   c[0][1] = sx(int'(w[2][26:18]), 9);
    c[1][0] = sx(int'(w[2][17:9]), 9);  c[2][0] = sx(int'(w[2][8:0]), 9);
    c[0][2] = sx(int'(w[4][26:18]), 9); c[1][2] = sx(int'(w[4][17:9]), 9);
    c[2][1] = sx(int'(w[4][8:0]), 9);
    for (int k = 0; k < 3; k++)
      o[k] = sx(int'({w[2*k+1][7:0], w[2*k][31:27]}), 13);
    sc  = int'(w[1][9:8]);
    sat = w[1][10];
    for (int i = 0; i < 3; i++) begin
      longint s = 0;
      longint n, r, lo, hi;
      for (int j = 0; j < 3; j++) s += longint'(c[i][j]) * longint'(px[8*j +: 8]);
      n  = (s + 64 * longint'(o[i])) * (longint'(1) << sc);
      r  = (n + 256) >>> 9;
      lo = sat ? 16 : 0;
      hi = sat ? ((i == 0) ? 235 : 240) : 255;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      res[8*i +: 8] = r[7:0];
    end
    return res;
  endfunction

  task automatic cfg_write(int idx, logic [31:0] d);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = d;
    if (idx < 6) bw_stage[idx] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_all(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2,
                         logic [31:0] w3, logic [31:0] w4, logic [31:0] w5);
    cfg_write(0, w0); cfg_write(1, w1); cfg_write(2, w2);
    cfg_write(3, w3); cfg_write(4, w4); cfg_write(5, w5);
  endtask

  // use_lit: push the hand-computed value; otherwise the model value.
  task automatic send(logic [23:0] d, bit sof, bit use_lit, logic [23:0] lit, string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    s_valid = 1'b1; s_sof = sof; s_data = d;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    if (sof) for (int k = 0; k < 6; k++) bw_act[k] = bw_stage[k];
    exp_q.push_back(use_lit ? lit : model(bw_act, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    ready_pct = 100;
    idle(1);
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    idle(2);
    chk(exp_q.size() == 0, "R10", "pixels still owed after drain", exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    m_ready = ($urandom_range(99) < ready_pct);
  end

  always @(negedge clk) begin
    #2;
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected output pixel", m_data, 0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(m_data == e, t, "output pixel", m_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    logic [31:0] id0;
    void'($urandom(32'd1234));
    id0 = (32'd128 << 18) | (32'd128 << 9) | 32'd128;
    for (int k = 0; k < 6; k++) begin
      bw_stage[k] = '0;
      bw_act[k]   = '0;
    end
    bw_stage[0] = id0; bw_stage[1] = 32'h200;
    bw_act[0]   = id0; bw_act[1]   = 32'h200;

    // R1: reset state
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    #3;
    chk(s_ready == 1'b1, "R11", "s_ready with empty output", s_ready, 1);

    // R9: latency, R1: pass-through after reset
    ready_pct = 100;
    send(24'h123456, 1'b0, 1'b1, 24'h123456, "R1");
    @(negedge clk);
    s_valid = 1'b0;
    #3 chk(m_valid == 1'b0, "R9", "valid one edge after accept", m_valid, 0);
    @(negedge clk);
    #3 chk(m_valid == 1'b0, "R9", "valid two edges after accept", m_valid, 0);
    @(negedge clk);
    #3 chk(m_valid == 1'b1, "R9", "valid three edges after accept", m_valid, 1);
    chk(m_data == 24'h123456, "R9", "data at latency", m_data, 24'h123456);
    drain();

    // R10: stall holds the pipeline full
    ready_pct = 0;
    send(24'h0a0b0c, 1'b0, 1'b1, 24'h0a0b0c, "R10");
    send(24'h1a1b1c, 1'b0, 1'b1, 24'h1a1b1c, "R10");
    send(24'h2a2b2c, 1'b0, 1'b1, 24'h2a2b2c, "R10");
    idle(1);
    #3;
    held = m_data;
    chk(s_ready == 1'b0, "R10", "s_ready while full and stalled", s_ready, 0);
    idle(1);
    #3;
    chk(m_valid == 1'b1, "R10", "valid held under stall", m_valid, 1);
    chk(m_data == held, "R10", "data held under stall", m_data, held);
    drain();

    // R8: staged write without frame start has no effect; R6 after sof
    cfg_write(1, 32'h600);
    send(24'hff00ff, 1'b0, 1'b1, 24'hff00ff, "R8");
    send(24'hff00ff, 1'b1, 1'b1, 24'hf010eb, "R6");
    drain();

    // R5: clamp to 0..255, offsets +100.0 and -100.0
    cfg_all(id0 | (32'd16 << 27), 32'h200 | 32'd12, 0, 0, 0, 0);
    send(24'h140ac8, 1'b1, 1'b1, 24'h140aff, "R5");
    cfg_all(id0 | (32'd16 << 27), 32'h200 | 32'd243, 0, 0, 0, 0);
    send(24'h140a64, 1'b1, 1'b1, 24'h140a00, "R5");
    drain();

    // R2/R3: coefficient 469 is -43, offset 50.0, gain code 1
    cfg_all((32'd469 << 18) | (32'd8 << 27), 32'h100 | 32'd6, 0, 0, 0, 0);
    send(24'h0000c8, 1'b1, 1'b1, 24'h000010, "R2");
    // R7: off-diagonal fields c01, c10, c20 in word 2
    cfg_all(0, 32'h200, (32'd128 << 18) | (32'd128 << 9) | 32'd128, 0, 0, 0);
    send(24'h302010, 1'b1, 1'b1, 24'h101020, "R7");
    // R7: index above 5 is ignored (c01 set stays)
    cfg_write(7, 32'hffffffff);
    send(24'h302010, 1'b1, 1'b1, 24'h101020, "R7");
    drain();

    // R4: rounding at each gain code
    cfg_all(32'd1 << 18, 32'h100, 0, 0, 0, 0);
    send(24'h000080, 1'b1, 1'b1, 24'h000001, "R4");
    send(24'h00007f, 1'b0, 1'b1, 24'h000000, "R4");
    cfg_all(32'd255 << 18, 32'h000, 0, 0, 0, 0);
    send(24'h0000ff, 1'b1, 1'b1, 24'h00007f, "R4");
    cfg_all(32'd64 << 18, 32'h300, 0, 0, 0, 0);
    send(24'h000064, 1'b1, 1'b1, 24'h000064, "R4");
    drain();

    // Random traffic with stalls and parameter changes (R2, R3, R4, R8, R10)
    for (int n = 0; n < 2500; n++) begin
      bit sof = 1'b0;
      ready_pct = 40 + $urandom_range(60);
      if ($urandom_range(59) == 0) begin
        for (int k = 0; k < 6; k++) cfg_write(k, $urandom());
        sof = 1'b1;
      end else if ($urandom_range(99) == 0) begin
        cfg_write($urandom_range(5), $urandom());
      end
      if ($urandom_range(7) == 0) idle(1 + $urandom_range(2));
      send(24'($urandom()), sof, 1'b0, 24'h0, "R2");
    end
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule